// File: doc/BRIEF.md
# SPI Frame Clock and Delay Timer

This block produces the serial clock and the chip-select framing for one SPI master frame, all from the system clock. A single attribute word describes the frame. It sets the SCK divisor, three framing delays, the frame length, and the clock polarity and phase. A one-cycle start pulse begins the frame. The block then drives select low, waits the lead delay, and toggles SCK once for each edge of the frame. After the last edge it waits the trail delay, releases select, and holds off for the gap delay. When the gap has expired it pulses done.

Alongside SCK the block gives one-cycle strobes that mark where the data path should sample or shift. Both strobes follow the programmed clock phase. The block does no data shifting and has no buffering. A neighbouring shifter uses the strobes and the select output to move bits.

Top module: `spi_frame_timer`

## Requirements
- R1: After reset, `csN` is 1, `sck` is 0, and `done`, `sampleStb` and `shiftStb` are 0.
- R2: The attribute word has these fields: frame length minus one in bits [29:26], polarity in [25], phase in [24], gap prescaler in [23:22], gap scaler in [21:18], trail prescaler in [17:16], trail scaler in [15:12], lead prescaler in [11:10], lead scaler in [9:6], baud prescaler in [5:4] and baud scaler in [3:0].
- R3: The SCK period in system clocks is P×S. P is 2, 3, 5 or 7 for baud prescaler codes 0 to 3. S is 2, 4, 6 or 8 for baud scaler codes 0 to 3, and 2^code for codes 4 to 15. Each half period is exactly P×S/2 clocks.
- R4: Each delay is (2·p+1)·2^(n+1) clocks, where p is the 2-bit prescaler code and n is the 4-bit scaler code. The lead delay is the number of cycles from the cycle in which `csN` goes low to the cycle in which `sck` first changes. The lead delay uses its own codes.
- R5: The trail delay is the number of cycles from the last SCK change to the cycle in which `csN` returns to 1. The trail delay uses its own codes.
- R6: After `csN` returns to 1, the gap delay runs. `done` is 1 for exactly one cycle, gap-delay cycles after the release. A start is accepted again from that cycle on.
- R7: SCK takes the frame's polarity bit as its level in the same cycle that `csN` goes low. It ends the frame at that level, and it does not change while select is released.
- R8: Each SCK change gives a strobe in the cycle in which the new level appears. With phase 0, leading edges (odd-numbered edges) strobe `sampleStb` and trailing edges strobe `shiftStb`. With phase 1 the roles swap.
- R9: A frame has B = L+1 bits and 2·B SCK edges, where L is the length field. A length field below 3 is treated as 3, so frames run from 4 to 16 bits.
- R10: The attribute word is captured when a start is accepted. Changing the attribute word during a frame does not alter that frame. A start pulse while a frame or its gap is running is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a frame when the block is idle |
| attr | input | 30 | Frame attribute word (fields in R2) |
| csN | output | 1 | Active-low frame select |
| sck | output | 1 | Serial clock |
| sampleStb | output | 1 | One-cycle strobe at each sampling edge |
| shiftStb | output | 1 | One-cycle strobe at each shifting edge |
| done | output | 1 | One-cycle pulse when the gap delay ends |

## Verification
The hardest case to reach from the ports is a frame whose attribute word changes, and which receives a second start, while the frame is still running. The bench has disturbed frames for this case. In them it writes random attribute values and a start pulse a few cycles after the frame has begun. It then checks every cycle of the waveform against the timing of the original word. Directed frames add the rest of the corner cases: a length field below the minimum, the longest frame, large delay scalers, unequal lead and trail settings, and a slow SCK divisor. Random frames then vary polarity, phase and every code together.

// File: rtl/spi_frame_timer_pkg.sv
package spi_frame_timer_pkg;

  localparam int ATTR_W = 30;

  typedef struct packed {
    logic [3:0] frameM1;
    logic       cpol;
    logic       cpha;
    logic [1:0] gapPre;
    logic [3:0] gapScl;
    logic [1:0] trailPre;
    logic [3:0] trailScl;
    logic [1:0] leadPre;
    logic [3:0] leadScl;
    logic [1:0] brPre;
    logic [3:0] brScl;
  } tmAttr_t;

  typedef enum logic [1:0] {SEL_LEAD, SEL_HALF, SEL_TRAIL, SEL_GAP} ldSel_e;

  typedef struct packed {
    logic   latch;
    logic   load;
    ldSel_e sel;
    logic   toggle;
  } tmCmd_t;

  function automatic logic [31:0] baudPrime(input logic [1:0] code);
    case (code)
      2'd0:    baudPrime = 32'd2;
      2'd1:    baudPrime = 32'd3;
      2'd2:    baudPrime = 32'd5;
      default: baudPrime = 32'd7;
    endcase
  endfunction

  function automatic logic [31:0] baudScale(input logic [3:0] code);
    if (code < 4'd4) baudScale = 32'(code + 1) << 1;
    else             baudScale = 32'd1 << code;
  endfunction

  function automatic logic [31:0] dlyCycles(input logic [1:0] pre, input logic [3:0] scl);
    dlyCycles = (32'({pre, 1'b1})) << (32'(scl) + 32'd1);
  endfunction

endpackage

// File: rtl/spi_frame_timer_dp.sv
module spi_frame_timer_dp
  import spi_frame_timer_pkg::*;
#(
  parameter int CNT_W  = 19,
  parameter int EDGE_W = 6
) (
  input  logic    clk,
  input  logic    rstN,
  input  tmAttr_t attrIn,
  input  tmCmd_t  cmd,
  output logic    cntZero,
  output logic    lastEdge,
  output logic    sck,
  output logic    sampleStb,
  output logic    shiftStb
);

  tmAttr_t           attrQ;
  tmAttr_t           useAttr;
  logic [CNT_W-1:0]  cnt;
  logic [EDGE_W-1:0] edgeCnt;
  logic [EDGE_W-1:0] edgeTarget;
  logic [3:0]        bitsM1;
  logic [31:0]       loadV;
  logic              leading;
  logic              sampleNow;

  assign useAttr = cmd.latch ? attrIn : attrQ;
  assign bitsM1  = (attrQ.frameM1 < 4'd3) ? 4'd3 : attrQ.frameM1;
  assign edgeTarget = EDGE_W'((32'(bitsM1) + 32'd1) << 1);
  assign lastEdge  = (edgeCnt + 1'b1) == edgeTarget;
  assign cntZero   = (cnt == '0);
  assign leading   = ~edgeCnt[0];
  assign sampleNow = leading ^ attrQ.cpha;

  always_comb begin
    case (cmd.sel)
      SEL_LEAD:  loadV = dlyCycles(useAttr.leadPre, useAttr.leadScl);
      SEL_TRAIL: loadV = dlyCycles(useAttr.trailPre, useAttr.trailScl);
      SEL_GAP:   loadV = dlyCycles(useAttr.gapPre, useAttr.gapScl);
      default:   loadV = (baudPrime(useAttr.brPre) * baudScale(useAttr.brScl)) >> 1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attrQ     <= '0;
      sck       <= 1'b0;
      edgeCnt   <= '0;
      cnt       <= '0;
      sampleStb <= 1'b0;
      shiftStb  <= 1'b0;
    end else begin
      sampleStb <= cmd.toggle & sampleNow;
      shiftStb  <= cmd.toggle & ~sampleNow;
      if (cmd.latch) begin
        attrQ   <= attrIn;
        sck     <= attrIn.cpol;
        edgeCnt <= '0;
      end else if (cmd.toggle) begin
        sck     <= ~sck;
        edgeCnt <= edgeCnt + 1'b1;
      end
      if (cmd.load)      cnt <= CNT_W'(loadV - 32'd1);
      else if (!cntZero) cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/spi_frame_timer_ctrl.sv
module spi_frame_timer_ctrl
  import spi_frame_timer_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   cntZero,
  input  logic   lastEdge,
  output tmCmd_t cmd,
  output logic   csN,
  output logic   done
);

  typedef enum logic [2:0] {ST_IDLE, ST_LEAD, ST_SCK, ST_TRAIL, ST_GAP} state_e;
  state_e state, stateNext;

  always_comb begin
    cmd       = '{latch: 1'b0, load: 1'b0, sel: SEL_HALF, toggle: 1'b0};
    stateNext = state;
    case (state)
      ST_IDLE: if (start) begin
        cmd.latch = 1'b1;
        cmd.load  = 1'b1;
        cmd.sel   = SEL_LEAD;
        stateNext = ST_LEAD;
      end
      ST_LEAD: if (cntZero) begin
        cmd.toggle = 1'b1;
        cmd.load   = 1'b1;
        cmd.sel    = SEL_HALF;
        stateNext  = ST_SCK;
      end
      ST_SCK: if (cntZero) begin
        cmd.toggle = 1'b1;
        cmd.load   = 1'b1;
        cmd.sel    = lastEdge ? SEL_TRAIL : SEL_HALF;
        if (lastEdge) stateNext = ST_TRAIL;
      end
      ST_TRAIL: if (cntZero) begin
        cmd.load  = 1'b1;
        cmd.sel   = SEL_GAP;
        stateNext = ST_GAP;
      end
      ST_GAP: if (cntZero) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      csN   <= 1'b1;
      done  <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= (state == ST_GAP) && cntZero;
      if (state == ST_IDLE && start)            csN <= 1'b0;
      else if (state == ST_TRAIL && cntZero)    csN <= 1'b1;
    end
  end

endmodule

// File: rtl/spi_frame_timer.sv
module spi_frame_timer
  import spi_frame_timer_pkg::*;
#(
  parameter int CNT_W  = 19,
  parameter int EDGE_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [ATTR_W-1:0] attr,
  output logic              csN,
  output logic              sck,
  output logic              sampleStb,
  output logic              shiftStb,
  output logic              done
);

  tmCmd_t cmd;
  logic   cntZero;
  logic   lastEdge;

  spi_frame_timer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cntZero(cntZero),
    .lastEdge(lastEdge), .cmd(cmd), .csN(csN), .done(done)
  );

  spi_frame_timer_dp #(.CNT_W(CNT_W), .EDGE_W(EDGE_W)) u_dp (
    .clk(clk), .rstN(rstN), .attrIn(tmAttr_t'(attr)), .cmd(cmd),
    .cntZero(cntZero), .lastEdge(lastEdge), .sck(sck),
    .sampleStb(sampleStb), .shiftStb(shiftStb)
  );

endmodule

// File: rtl/spi_frame_timer_chk.sv
module spi_frame_timer_chk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sck,
  input logic sampleStb,
  input logic shiftStb,
  input logic done
);

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_released_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> csN);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleStb && shiftStb));

  // R8
  strobe_in_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb || shiftStb) |-> !csN);

  // R8
  strobe_on_edge_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb || shiftStb) |-> !$stable(sck));

  // R7
  idle_sck_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(csN) && csN) |-> $stable(sck));

endmodule

bind spi_frame_timer spi_frame_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck),
  .sampleStb(sampleStb), .shiftStb(shiftStb), .done(done)
);

// File: tb/spi_frame_timer_bench.sv
`timescale 1ns/1ps
module spi_frame_timer_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [29:0] attr = '0;
  logic        csN, sck, sampleStb, shiftStb, done;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  spi_frame_timer u_spi_frame_timer (
    .clk(clk), .rstN(rstN), .start(start), .attr(attr), .csN(csN),
    .sck(sck), .sampleStb(sampleStb), .shiftStb(shiftStb), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int primeOf(input int c);
    int t[4] = '{2, 3, 5, 7};
    return t[c];
  endfunction

  function automatic int sclOf(input int c);
    return (c < 4) ? 2 * (c + 1) : (1 << c);
  endfunction

  function automatic int dlyOf(input int p, input int n);
    return (2 * p + 1) * (1 << (n + 1));
  endfunction

  function automatic logic [29:0] mk(input int fm, cpol, cpha, gp, gs, tp, ts, lp, ls, bp, bs);
    return {4'(fm), 1'(cpol), 1'(cpha), 2'(gp), 4'(gs), 2'(tp), 4'(ts),
            2'(lp), 4'(ls), 2'(bp), 4'(bs)};
  endfunction

  task automatic runFrame(input logic [29:0] a, input bit disturb, input string tag);
    int e[33];
    int bits, half, nEdge, rel, doneAt, i;
    int cpol, cpha;
    int csBad, sckBad, stbBad, doneBad;
    int csA, csE, sckA, sckE, stbA, stbE, dnA, dnE;
    csBad = 0; sckBad = 0; stbBad = 0; doneBad = 0;
    csA = 0; csE = 0; sckA = 0; sckE = 0; stbA = 0; stbE = 0; dnA = 0; dnE = 0;
    cpol = int'(a[25]); cpha = int'(a[24]);
    bits = (int'(a[29:26]) < 3) ? 4 : int'(a[29:26]) + 1;
    half = primeOf(int'(a[5:4])) * sclOf(int'(a[3:0])) / 2;
    nEdge = 2 * bits;
    e[1] = dlyOf(int'(a[11:10]), int'(a[9:6]));
    for (int j = 2; j <= nEdge; j++) e[j] = e[j-1] + half;
    rel = e[nEdge] + dlyOf(int'(a[17:16]), int'(a[15:12]));
    doneAt = rel + dlyOf(int'(a[23:22]), int'(a[21:18]));
    @(negedge clk);
    attr = a;
    start = 1'b1;
    @(posedge clk);
    i = 0;
    while (i <= doneAt + 1) begin
      int tg, sampE, shiftE;
      @(negedge clk);
      tg = 0; sampE = 0; shiftE = 0;
      for (int j = 1; j <= nEdge; j++) begin
        if (e[j] <= i) tg++;
        if (e[j] == i) begin
          if (((j % 2) ^ cpha) == 1) sampE = 1; else shiftE = 1;
        end
      end
      if (int'(csN) != int'(i >= rel) && csBad == 0) begin
        csBad = 1; csA = int'(csN); csE = int'(i >= rel);
      end
      if (int'(sck) != (cpol ^ (tg % 2)) && sckBad == 0) begin
        sckBad = 1; sckA = int'(sck); sckE = cpol ^ (tg % 2);
      end
      if ((int'(sampleStb) != sampE || int'(shiftStb) != shiftE) && stbBad == 0) begin
        stbBad = 1; stbA = 2 * int'(sampleStb) + int'(shiftStb); stbE = 2 * sampE + shiftE;
      end
      if (int'(done) != int'(i == doneAt) && doneBad == 0) begin
        doneBad = 1; dnA = int'(done); dnE = int'(i == doneAt);
      end
      start = disturb && (i == 5);
      attr = (disturb && i >= 5) ? 30'($urandom) : a;
      @(posedge clk);
      i++;
    end
    check(csBad == 0, {tag, " R4 R5 select timing"}, csA, csE);
    check(sckBad == 0, {tag, " R3 R7 R9 sck waveform"}, sckA, sckE);
    check(stbBad == 0, {tag, " R8 strobes"}, stbA, stbE);
    check(doneBad == 0, {tag, " R6 done pulse"}, dnA, dnE);
  endtask

  initial begin
    int wd;
    wd = 0;
    while (!finished && wd < 190000) begin
      @(posedge clk);
      wd++;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual %0d expected below %0d", wd, 190000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && sck == 1'b0 && done == 1'b0 && !sampleStb && !shiftStb,
          "R1 reset state", {csN, sck, done, sampleStb, shiftStb}, 5'b10000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && sck == 1'b0 && done == 1'b0,
          "R1 idle after reset", {csN, sck, done}, 3'b100);

    // R2 directed field placements
    runFrame(mk(7, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), 0, "basic");
    runFrame(mk(0, 1, 0, 1, 1, 2, 0, 0, 2, 1, 1), 0, "R9 short clamp");
    runFrame(mk(15, 0, 1, 0, 0, 3, 1, 2, 3, 0, 3), 0, "R9 longest");
    runFrame(mk(3, 1, 1, 0, 2, 0, 0, 3, 1, 3, 5), 0, "R3 slow baud");
    runFrame(mk(4, 0, 0, 1, 9, 0, 0, 2, 8, 2, 0), 0, "R4 large delays");
    runFrame(mk(5, 1, 0, 0, 0, 3, 6, 0, 0, 1, 2), 0, "R5 long trail");
    runFrame(mk(6, 0, 1, 2, 1, 1, 2, 1, 3, 2, 2), 1, "R10 disturbed");
    runFrame(mk(8, 1, 1, 0, 1, 0, 3, 1, 0, 3, 1), 1, "R10 disturbed cpol");

    for (int k = 0; k < 24; k++) begin
      logic [29:0] a;
      a = mk($urandom_range(15), $urandom_range(1), $urandom_range(1),
             $urandom_range(3), $urandom_range(4), $urandom_range(3), $urandom_range(4),
             $urandom_range(3), $urandom_range(4), $urandom_range(3), $urandom_range(3));
      runFrame(a, (k % 4) == 3, "random R2");
    end

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule